// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small register-based processor. It takes a 32-bit instruction word and finds the operation code, the destination index and the two source indices in fixed fields. The two source indices go straight out to an external register file. The register file returns the two operand values in the same cycle. The block then computes a byte-wide add, subtract, AND, OR or XOR.

On the next rising clock edge the block registers three things: the 8-bit result, the destination index and a single-cycle write enable. In the same edge it registers a new status byte, built from the status byte the processor supplied with the instruction. Each instruction completes in one clock, so the processor advances its program counter by one per issued operation.

Arithmetic and logic operations follow different flag rules. Add and subtract produce carry, half-carry and overflow. The logic operations force overflow clear and keep carry and half-carry from the incoming status byte. For both classes the sign flag is always N xor V, taken after the other flags are updated.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `wr_en`, `wr_idx`, `result` and `status_out` all become 0 at that edge.
- R2: The operation code is `instr[31:24]`, the destination index is `instr[23:16]`, the first source index is `instr[15:8]` and the second source index is `instr[7:0]`. `src_a_idx` and `src_b_idx` follow the instruction combinationally.
- R3: The operation codes are 0x01 add, 0x02 subtract, 0x10 AND, 0x11 OR and 0x12 XOR. For an add, `result` is the low 8 bits of A+B, and carry (status bit 0) is set when the 9-bit unsigned sum is greater than 255.
- R4: For a subtract, `result` is the low 8 bits of A−B, and carry (bit 0) is set when a borrow occurs, that is, when A < B unsigned.
- R5: Zero (bit 1) is set exactly when the 8-bit result is 0, for every operation.
- R6: Negative (bit 2) equals bit 7 of the result, for every operation.
- R7: Add overflow (bit 3) is set when A and B both have bit 7 set and the result does not, or when A and B both have bit 7 clear and the result has it set.
- R8: Subtract overflow (bit 3) is set when A bit 7 is clear, B bit 7 is set and the result bit 7 is set, or when A bit 7 is set, B bit 7 is clear and the result bit 7 is clear.
- R9: Sign (bit 4) equals N xor V of the new status byte.
- R10: Half-carry (bit 5) is the carry out of bit 3 for an add and the borrow into bit 4 for a subtract.
- R11: AND, OR and XOR clear overflow and keep carry (bit 0) and half-carry (bit 5) from `status_in`. Their result is the bitwise function of A and B.
- R12: Bits 7:6 of `status_out` equal bits 7:6 of `status_in` for every executed operation.
- R13: An `issue` with a listed operation code gives a `wr_en` pulse exactly one cycle later, with `wr_idx` set to the destination field. Nothing else raises `wr_en`.
- R14: A cycle without `issue`, or with an unlisted operation code, leaves `wr_en` low and keeps `result`, `wr_idx` and `status_out` at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 8 | Value read for the first source index |
| opnd_b | input | 8 | Value read for the second source index |
| status_in | input | 8 | Current status byte |
| src_a_idx | output | 8 | First source register index |
| src_b_idx | output | 8 | Second source register index |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 8 | Destination register index |
| result | output | 8 | Operation result |
| status_out | output | 8 | Updated status byte |

## Verification
Within a single clock edge the block does two things at once. It produces the arithmetic flags, carry, half-carry and overflow. It also keeps or forces the flags that an operation class must not touch: carry and half-carry kept and overflow forced clear for the logic class, and bits 7:6 kept for every class.

The bench provokes this overlap by issuing logic operations back to back with arithmetic operations that leave carry, half-carry and overflow set. It also issues both classes with a mix of incoming status bytes, all-ones, all-zeros and alternating, so that a flag taken from the wrong source shows up in the very next cycle.

A behavioural model computes each expected status bit with integer arithmetic and compares it one bit at a time on every clock. This also covers the idle cycles, where the outputs must hold.

// File: rtl/byte_alu_pkg.sv
// Package: shared operation codes, the decoded operation type and the
// status bit positions of the byte ALU.
// Assumes the 8-bit operation code field and the status layout below.
package byte_alu_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_ADD = 8'h01;
    localparam logic [OPC_W-1:0] OPC_SUB = 8'h02;
    localparam logic [OPC_W-1:0] OPC_AND = 8'h10;
    localparam logic [OPC_W-1:0] OPC_OR  = 8'h11;
    localparam logic [OPC_W-1:0] OPC_XOR = 8'h12;

    // Status byte bit positions
    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_N = 2;
    localparam int ST_V = 3;
    localparam int ST_S = 4;
    localparam int ST_H = 5;
    localparam int ST_W = 8;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

endpackage

// File: rtl/byte_alu_decode.sv
// Module: turns the operation code field into an operation and its class.
// Assumes unlisted codes are not ALU work and must write nothing.
module byte_alu_decode
    import byte_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_op_e          op,
    output logic             is_arith,
    output logic             is_logic,
    output logic             is_sub,
    output logic_fn_e        lg_fn
);

    // Map the operation code to a decoded operation.
    always_comb begin
        case (opcode)
            OPC_ADD: op = OP_ADD;
            OPC_SUB: op = OP_SUB;
            OPC_AND: op = OP_AND;
            OPC_OR:  op = OP_OR;
            OPC_XOR: op = OP_XOR;
            default: op = OP_NONE;
        endcase
    end

    // Derive the operation class and the selectors of the two units.
    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_SUB);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        is_sub   = (op == OP_SUB);
        case (op)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            default: lg_fn = LG_AND;
        endcase
    end

endmodule

// File: rtl/byte_alu_arith.sv
// Module: add/subtract datapath with carry, half-carry and overflow.
// Assumes unsigned operands. For a subtract, carry means borrow out of the
// top bit and half-carry means borrow into bit NIB.
module byte_alu_arith #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         cy,
    output logic         hc,
    output logic         ov
);

    localparam int MSB = W - 1;

    logic [W:0]   full;
    logic [NIB:0] low;

    // Full-width and low-nibble sums or differences, each one bit wider.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
        end else begin
            full = {1'b0, a} + {1'b0, b};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
        end
    end

    // Result, carry or borrow, half-carry, and signed overflow.
    always_comb begin
        r  = full[W-1:0];
        cy = full[W];
        hc = low[NIB];
        if (sub)
            ov = (~a[MSB] &  b[MSB] &  r[MSB]) | ( a[MSB] & ~b[MSB] & ~r[MSB]);
        else
            ov = ( a[MSB] &  b[MSB] & ~r[MSB]) | (~a[MSB] & ~b[MSB] &  r[MSB]);
    end

endmodule

// File: rtl/byte_alu_logic.sv
// Module: bitwise AND/OR/XOR, built one bit slice at a time.
// Assumes the function selector is one of the three logic functions.
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] r
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Per-bit function select.
            always_comb begin
                case (fn)
                    LG_OR:   r[gi] = a[gi] | b[gi];
                    LG_XOR:  r[gi] = a[gi] ^ b[gi];
                    default: r[gi] = a[gi] & b[gi];
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/byte_alu.sv
// Module: single-cycle byte ALU. It decodes the instruction fields, computes
// the result and the new status byte, and registers them together with a
// one-cycle destination write strobe.
// Assumes the register file returns opnd_a/opnd_b for src_a_idx/src_b_idx in
// the same cycle, and that status_in is the current status byte.
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 8,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [ST_W-1:0]    status_in,
    output logic [IDX_W-1:0]   src_a_idx,
    output logic [IDX_W-1:0]   src_b_idx,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DATA_W-1:0]  result,
    output logic [ST_W-1:0]    status_out
);

    localparam int SRCB_LO = 0;
    localparam int SRCA_LO = SRCB_LO + IDX_W;
    localparam int DST_LO  = SRCA_LO + IDX_W;
    localparam int OPC_LO  = DST_LO + IDX_W;
    localparam int NIB     = DATA_W / 2;

    alu_op_e      op;
    logic         is_arith, is_logic, is_sub;
    logic_fn_e    lg_fn;
    logic [DATA_W-1:0] ar_r, lg_r, res_nx;
    logic         ar_c, ar_h, ar_v;
    logic [ST_W-1:0] st_nx;
    logic         take;

    byte_alu_decode u_dec (
        .opcode   (instr[OPC_LO +: OPC_W]),
        .op       (op),
        .is_arith (is_arith),
        .is_logic (is_logic),
        .is_sub   (is_sub),
        .lg_fn    (lg_fn)
    );

    byte_alu_arith #(.W(DATA_W), .NIB(NIB)) u_arith (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (is_sub),
        .r   (ar_r),
        .cy  (ar_c),
        .hc  (ar_h),
        .ov  (ar_v)
    );

    byte_alu_logic #(.W(DATA_W)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (lg_fn),
        .r  (lg_r)
    );

    // Source indices go straight out to the register file.
    always_comb begin
        src_a_idx = instr[SRCA_LO +: IDX_W];
        src_b_idx = instr[SRCB_LO +: IDX_W];
    end

    // Choose the result and build the new status byte by operation class.
    always_comb begin
        res_nx = is_arith ? ar_r : lg_r;
        st_nx  = status_in;
        if (is_arith) begin
            st_nx[ST_C] = ar_c;
            st_nx[ST_H] = ar_h;
            st_nx[ST_V] = ar_v;
        end else begin
            st_nx[ST_V] = 1'b0;
        end
        st_nx[ST_Z] = (res_nx == '0);
        st_nx[ST_N] = res_nx[DATA_W-1];
        st_nx[ST_S] = st_nx[ST_N] ^ st_nx[ST_V];
        take = issue && (op != OP_NONE) && (is_arith || is_logic);
    end

    // Output registers: load on an executed operation, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            result     <= '0;
            status_out <= '0;
        end else begin
            wr_en <= take;
            if (take) begin
                wr_idx     <= instr[DST_LO +: IDX_W];
                result     <= res_nx;
                status_out <= st_nx;
            end
        end
    end

endmodule

// File: rtl/byte_alu_checker.sv
// Module: temporal checks on the byte ALU ports, attached by bind.
// Assumes the default 8-bit data and the status layout of the package.
module byte_alu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [7:0]  status_in,
    input logic        wr_en,
    input logic [7:0]  wr_idx,
    input logic [7:0]  result,
    input logic [7:0]  status_out
);

    // R13: a write strobe only follows an issue
    assert_wr_follows_issue_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(issue));

    // R14: no issue leaves the outputs untouched
    assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!wr_en && $stable(result) && $stable(status_out) && $stable(wr_idx)));

    // R9: sign equals N xor V
    assert_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (status_out[4] == (status_out[2] ^ status_out[3])));

    // R5: zero flag tracks the registered result
    assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (status_out[1] == (result == 8'h00)));

    // R6: negative flag tracks result bit 7
    assert_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (status_out[2] == result[7]));

    // R12: upper status bits pass through
    assert_upper_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (status_out[7:6] == $past(status_in[7:6])));

endmodule

bind byte_alu byte_alu_checker u_byte_alu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .status_in  (status_in),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .result     (result),
    .status_out (status_out)
);

// File: tb/test_byte_alu.sv
`timescale 1ns/1ps
module test_byte_alu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue;
    logic [31:0] instr;
    logic [7:0]  opnd_a, opnd_b, status_in;
    logic [7:0]  src_a_idx, src_b_idx, wr_idx, result, status_out;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int exp_wr, exp_idx, exp_res, exp_st;
    string res_tag;

    always #2.5 clk = ~clk;

    byte_alu i_byte_alu (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .status_in(status_in),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .wr_en(wr_en),
        .wr_idx(wr_idx), .result(result), .status_out(status_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of one issued cycle.
    task automatic model(input bit iss, input int opc, input int dst,
                         input int a, input int b, input int st);
        int r, c, h, v, n, z;
        bit known;
        known = (opc == 1) || (opc == 2) || (opc == 'h10) || (opc == 'h11) || (opc == 'h12);
        exp_wr = (iss && known) ? 1 : 0;
        if (!exp_wr) return;
        c = st & 1; h = (st >> 5) & 1; v = 0;
        if (opc == 1) begin
            r = (a + b) & 255; c = (a + b) > 255 ? 1 : 0;
            h = ((a & 15) + (b & 15)) > 15 ? 1 : 0;
            v = (((a & b & ~r) | (~a & ~b & r)) >> 7) & 1;
            res_tag = "R3";
        end else if (opc == 2) begin
            r = (a - b) & 255; c = (a < b) ? 1 : 0;
            h = ((a & 15) < (b & 15)) ? 1 : 0;
            v = (((~a & b & r) | (a & ~b & ~r)) >> 7) & 1;
            res_tag = "R4";
        end else begin
            if (opc == 'h10) r = a & b;
            else if (opc == 'h11) r = a | b;
            else r = a ^ b;
            res_tag = "R11";
        end
        n = (r >> 7) & 1;
        z = (r == 0) ? 1 : 0;
        exp_res = r;
        exp_idx = dst;
        exp_st  = (st & 'hC0) | (h << 5) | ((n ^ v) << 4) | (v << 3) | (n << 2) | (z << 1) | c;
    endtask

    // Drive one cycle, apply the model at the edge, compare at the next falling edge.
    task automatic step(input bit iss, input int opc, input int dst,
                        input int a, input int b, input int st);
        issue     = iss;
        instr     = {opc[7:0], dst[7:0], dst[7:0] + 8'd1, dst[7:0] ^ 8'h5A};
        opnd_a    = a[7:0];
        opnd_b    = b[7:0];
        status_in = st[7:0];
        #1;
        chk("R2 src_a", src_a_idx, (dst + 1) & 255);
        chk("R2 src_b", src_b_idx, dst ^ 'h5A);
        @(posedge clk);
        model(iss, opc, dst, a, b, st);
        @(negedge clk);
        chk("R13 wr_en", wr_en, exp_wr);
        chk("R13 R14 wr_idx", wr_idx, exp_idx);
        chk(exp_wr ? res_tag : "R14 hold", result, exp_res);
        chk((opc == 2) ? "R4 carry" : ((opc == 1) ? "R3 carry" : "R11 carry"), status_out[0], exp_st & 1);
        chk("R5 zero", status_out[1], (exp_st >> 1) & 1);
        chk("R6 neg", status_out[2], (exp_st >> 2) & 1);
        chk((opc == 2) ? "R8 ovf" : ((opc == 1) ? "R7 ovf" : "R11 ovf"), status_out[3], (exp_st >> 3) & 1);
        chk("R9 sign", status_out[4], (exp_st >> 4) & 1);
        chk((opc < 3) ? "R10 half" : "R11 half", status_out[5], (exp_st >> 5) & 1);
        chk("R12 upper", status_out[7:6], (exp_st >> 6) & 3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lf;
        int ops[5] = '{1, 2, 'h10, 'h11, 'h12};
        rst_n = 1'b0; issue = 1'b0; instr = '0;
        opnd_a = '0; opnd_b = '0; status_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 wr_idx", wr_idx, 0);
        chk("R1 result", result, 0);
        chk("R1 status", status_out, 0);
        exp_wr = 0; exp_idx = 0; exp_res = 0; exp_st = 0;
        rst_n = 1'b1;
        // add corners: R3 R7 R10
        step(1, 1, 3, 'h7F, 'h01, 'h00);
        step(1, 1, 4, 'hFF, 'h01, 'hC0);
        step(1, 1, 5, 'h80, 'h80, 'h40);
        step(1, 1, 6, 'h0F, 'h01, 'h80);
        // subtract corners: R4 R8 R10
        step(1, 2, 7, 'h00, 'h01, 'h00);
        step(1, 2, 8, 'h80, 'h01, 'hFF);
        step(1, 2, 9, 'h7F, 'hFF, 'h00);
        step(1, 2, 10, 'h05, 'h05, 'h00);
        step(1, 2, 11, 'h10, 'h01, 'h00);
        // logic class after flags were set: R11 R12
        step(1, 1, 12, 'hFF, 'hFF, 'h00);
        step(1, 'h10, 13, 'hF0, 'h0F, 'hFF);
        step(1, 'h11, 14, 'h80, 'h01, 'h29);
        step(1, 'h12, 15, 'hAA, 'hAA, 'h55);
        step(1, 'h12, 16, 'hAA, 'h55, 'h00);
        // no effect: R14
        step(0, 1, 20, 'h01, 'h01, 'hFF);
        step(1, 'h55, 21, 'h01, 'h01, 'hFF);
        step(1, 'h00, 22, 'h00, 'h00, 'h00);
        step(0, 0, 0, 0, 0, 0);
        // back-to-back stream with idle gaps
        lf = 'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = ((lf >> 1) ^ ((lf & 1) ? 'hB400 : 0)) & 'hFFFF;
            step(((lf >> 3) & 7) != 0, (i % 11 == 7) ? 'h33 : ops[lf % 5],
                 (lf >> 4) & 255, lf & 255, (lf >> 8) & 255, (lf * 7) & 255);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule